// File: doc/BRIEF.md
# 16-bit Multiply/Divide Unit

This arithmetic unit serves a small register-based processor. It takes two 16-bit operands, an operation code and a destination register index. It returns its results as write requests to the processor's register file, together with carry and zero flag updates. There is one write port, so results leave one write per cycle.

Multiplication always forms the full 32-bit product. The upper half is written to register 0 first, and the lower half is written to the named destination in the following cycle. When the destination is register 0, the second write therefore overwrites the first, and only the lower half remains.

Division and remainder run on a 16-step restoring divider that works on operand magnitudes, and the signs are applied at the end. Two divides are faults: a divisor of zero, and signed -32768 divided by -1. For a fault the unit writes no register, raises carry and pulses a fault line for one cycle. Raising an interrupt for a fault is left to the surrounding processor.

Top module: `muldiv_unit`

## Requirements
- R1: Operation codes on `op_i`: 0 unsigned multiply, 1 signed multiply, 2 unsigned divide, 3 signed divide, 4 unsigned remainder, 5 signed remainder. A start is accepted only in a cycle where `busy_o` is low and the code is 0 to 5.
- R2: Unsigned multiply writes product bits 31:16 to register index 0 in the first cycle after the start. It writes bits 15:0 to `dst_i` in the second cycle, and that second cycle also raises `done_o`.
- R3: Signed multiply writes the two's-complement 32-bit product in the same two-write order. Its low half equals the low half of the unsigned product of the same operands.
- R4: With `dst_i` = 0, the writes go to index 0 in the order high half, then low half, so register 0 ends up holding the low half.
- R5: The multiply carry flag is set when the product does not fit in 16 bits. For unsigned that means a nonzero high half; for signed it means a high half that is not the sign extension of the low half. The zero flag is set when the low half is zero.
- R6: Unsigned divide and remainder write the truncated quotient or the remainder to `dst_i`. 0x8000 divided by 0xFFFF is an ordinary unsigned divide with quotient 0 and remainder 0x8000.
- R7: A signed quotient truncates toward zero. A signed remainder takes the dividend's sign: 5 rem -3 = 2, -5 rem 3 = -2, -5 rem -3 = -2.
- R8: A divide or remainder with a zero divisor makes no register write. In the first cycle after the start it raises `done_o`, `fault_o` and `flag_we_o`, with carry 1 and zero 0. `fault_o` is high for exactly that one cycle.
- R9: A signed divide or remainder of 0x8000 by 0xFFFF behaves as the fault of R8.
- R10: A non-faulting divide or remainder clears carry. It sets zero exactly when the written value is zero.
- R11: A non-faulting divide or remainder makes its single write, with `done_o`, in the 17th cycle after the start edge. `busy_o` is high from the first cycle after a start through the `done_o` cycle, and low in the next cycle.
- R12: A start while busy, or with code 6 or 7, is ignored. The operation in flight is unchanged, and the ignored request produces no write, no `done_o` and no `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin an operation |
| op_i | input | 3 | Operation code |
| a_i | input | 16 | Multiplicand or dividend |
| b_i | input | 16 | Multiplier or divisor |
| dst_i | input | 3 | Destination register index |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Final cycle of an operation |
| wr_en_o | output | 1 | Register write request |
| wr_idx_o | output | 3 | Register index to write |
| wr_data_o | output | 16 | Data to write |
| flag_we_o | output | 1 | Carry and zero flag update strobe |
| carry_o | output | 1 | New carry flag |
| zero_o | output | 1 | New zero flag |
| fault_o | output | 1 | One-cycle fault indication for a divide |

## Verification
On every cycle the assertions check the handshake and ordering rules:
- an accepted multiply writes register 0 in the next cycle, and a write without `done_o` is followed by the closing write;
- a zero divisor faults in the next cycle and makes no write, and `fault_o` lasts one cycle;
- `busy_o` stays high until `done_o` and drops right after it;
- the divider's result strobe follows its sixteenth step.

Only the bench's scenarios can show the arithmetic values:
- signed and unsigned products and their overflow carry;
- quotient truncation and the remainder signs;
- the last-write-wins outcome when the destination is register 0;
- the signed overflow fault set against the unsigned divide of the same bit patterns;
- the exact 17-cycle divide latency.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [2:0] {
    OP_MULU = 3'd0,
    OP_MULS = 3'd1,
    OP_DIVU = 3'd2,
    OP_DIVS = 3'd3,
    OP_REMU = 3'd4,
    OP_REMS = 3'd5
  } mdu_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL_HI,
    ST_MUL_LO,
    ST_DIV,
    ST_FAULT
  } mdu_state_e;

  function automatic logic op_is_mul(input logic [2:0] op);
    return (op == OP_MULU) || (op == OP_MULS);
  endfunction

  function automatic logic op_is_rem(input logic [2:0] op);
    return (op == OP_REMU) || (op == OP_REMS);
  endfunction

  function automatic logic op_is_valid(input logic [2:0] op);
    return op <= OP_REMS;
  endfunction

  // signed variants are the odd codes
  function automatic logic op_is_signed(input logic [2:0] op);
    return op[0];
  endfunction
endpackage

// File: rtl/mdu_mul.sv
module mdu_mul #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           sgn_i,
  output logic [2*W-1:0] prod_o,
  output logic           ovf_o
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] a_ext, b_ext;

  always_comb begin
    a_ext  = {{W{sgn_i & a_i[W-1]}}, a_i};
    b_ext  = {{W{sgn_i & b_i[W-1]}}, b_i};
    // low 2W bits of the extended product are correct for both signednesses
    prod_o = a_ext * b_ext;
    if (sgn_i) ovf_o = prod_o[PW-1:W] != {W{prod_o[W-1]}};
    else       ovf_o = prod_o[PW-1:W] != '0;
  end
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         busy_o,
  output logic         valid_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, valid_q;
  logic [W:0]    shifted, trial;
  logic [W-1:0]  rem_nxt, quo_nxt;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, dvs_q};
    if (!trial[W]) begin
      rem_nxt = trial[W-1:0];
      quo_nxt = {quo_q[W-2:0], 1'b1};
    end else begin
      rem_nxt = shifted[W-1:0];
      quo_nxt = {quo_q[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      quo_q   <= '0;
      dvs_q   <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      valid_q <= 1'b0;
    end else if (start_i) begin
      rem_q   <= '0;
      quo_q   <= dvd_i;
      dvs_q   <= dvs_i;
      cnt_q   <= '0;
      run_q   <= 1'b1;
      valid_q <= 1'b0;
    end else if (run_q) begin
      rem_q <= rem_nxt;
      quo_q <= quo_nxt;
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        run_q   <= 1'b0;
        valid_q <= 1'b1;
      end
    end else begin
      valid_q <= 1'b0;
    end
  end

  assign busy_o  = run_q;
  assign valid_o = valid_q;
  assign quo_o   = quo_q;
  assign rem_o   = rem_q;

  // R11
  div_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q == LAST && !start_i) |=> valid_o);
  // R11
  div_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import mdu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned RIDX_W = 3,
  parameter int unsigned HI_REG = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [RIDX_W-1:0] dst_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              wr_en_o,
  output logic [RIDX_W-1:0] wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              flag_we_o,
  output logic              carry_o,
  output logic              zero_o,
  output logic              fault_o
);
  localparam int unsigned W  = DATA_W;
  localparam int unsigned PW = 2 * W;
  localparam logic [W-1:0]      S_MIN  = {1'b1, {(W-1){1'b0}}};
  localparam logic [RIDX_W-1:0] HI_IDX = RIDX_W'(HI_REG);

  mdu_state_e state_q;
  logic [RIDX_W-1:0] dst_q;
  logic [PW-1:0]     prod, prod_q;
  logic              ovf, ovf_q;
  logic              is_rem_q, qneg_q, rneg_q;

  logic is_mul, sgn, a_neg, b_neg, fault_now, start_ok, div_start;
  logic [W-1:0] mag_a, mag_b, quo, rem, res;
  logic div_busy, div_valid;

  always_comb begin
    is_mul    = op_is_mul(op_i);
    sgn       = op_is_signed(op_i);
    a_neg     = sgn & a_i[W-1];
    b_neg     = sgn & b_i[W-1];
    mag_a     = a_neg ? (~a_i + 1'b1) : a_i;
    mag_b     = b_neg ? (~b_i + 1'b1) : b_i;
    fault_now = !is_mul && ((b_i == '0) || (sgn && a_i == S_MIN && b_i == '1));
    start_ok  = start_i && (state_q == ST_IDLE) && op_is_valid(op_i);
    div_start = start_ok && !is_mul && !fault_now;
  end

  mdu_mul #(.W(W)) u_mul (
    .a_i    (a_i),
    .b_i    (b_i),
    .sgn_i  (sgn),
    .prod_o (prod),
    .ovf_o  (ovf)
  );

  mdu_div #(.W(W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (div_start),
    .dvd_i   (mag_a),
    .dvs_i   (mag_b),
    .busy_o  (div_busy),
    .valid_o (div_valid),
    .quo_o   (quo),
    .rem_o   (rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      dst_q    <= '0;
      prod_q   <= '0;
      ovf_q    <= 1'b0;
      is_rem_q <= 1'b0;
      qneg_q   <= 1'b0;
      rneg_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_ok) begin
          dst_q    <= dst_i;
          prod_q   <= prod;
          ovf_q    <= ovf;
          is_rem_q <= op_is_rem(op_i);
          qneg_q   <= a_neg ^ b_neg;
          rneg_q   <= a_neg;
          if (is_mul)         state_q <= ST_MUL_HI;
          else if (fault_now) state_q <= ST_FAULT;
          else                state_q <= ST_DIV;
        end
        ST_MUL_HI: state_q <= ST_MUL_LO;
        ST_DIV:    if (div_valid) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (is_rem_q) res = rneg_q ? (~rem + 1'b1) : rem;
    else          res = qneg_q ? (~quo + 1'b1) : quo;
  end

  always_comb begin
    busy_o    = state_q != ST_IDLE;
    done_o    = 1'b0;
    wr_en_o   = 1'b0;
    wr_idx_o  = dst_q;
    wr_data_o = '0;
    flag_we_o = 1'b0;
    carry_o   = 1'b0;
    zero_o    = 1'b0;
    fault_o   = 1'b0;
    unique case (state_q)
      ST_MUL_HI: begin
        wr_en_o   = 1'b1;
        wr_idx_o  = HI_IDX;
        wr_data_o = prod_q[PW-1:W];
      end
      ST_MUL_LO: begin
        wr_en_o   = 1'b1;
        wr_data_o = prod_q[W-1:0];
        done_o    = 1'b1;
        flag_we_o = 1'b1;
        carry_o   = ovf_q;
        zero_o    = prod_q[W-1:0] == '0;
      end
      ST_DIV: if (div_valid) begin
        wr_en_o   = 1'b1;
        wr_data_o = res;
        done_o    = 1'b1;
        flag_we_o = 1'b1;
        zero_o    = res == '0;
      end
      ST_FAULT: begin
        done_o    = 1'b1;
        flag_we_o = 1'b1;
        carry_o   = 1'b1;
        fault_o   = 1'b1;
      end
      default: ;
    endcase
  end

  // R2
  mul_hi_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && (op_i == OP_MULU || op_i == OP_MULS))
      |=> (wr_en_o && !done_o && wr_idx_o == HI_IDX));
  // R4
  mul_lo_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !done_o) |=> (wr_en_o && done_o));
  // R8
  div_zero_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_is_valid(op_i) && !op_is_mul(op_i) && b_i == '0)
      |=> (fault_o && carry_o && !wr_en_o));
  // R8
  fault_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o);
  // R11
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  // R11
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  // R11
  div_core_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !div_busy);
endmodule

// File: tb/sim_muldiv_unit.sv
module sim_muldiv_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] op = '0;
  logic [15:0] a = '0, b = '0;
  logic [2:0] dst = '0;
  logic busy, done, wr_en, flag_we, carry, zero, fault;
  logic [2:0] wr_idx;
  logic [15:0] wr_data;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  muldiv_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
    .dst_i(dst), .busy_o(busy), .done_o(done), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .wr_data_o(wr_data), .flag_we_o(flag_we), .carry_o(carry), .zero_o(zero),
    .fault_o(fault)
  );

  logic [2:0]  c_idx [0:1];
  logic [15:0] c_dat [0:1];
  int c_nwr, c_cyc, c_nobusy;
  logic c_flt, c_cy, c_zf, c_fwe, c_quiet;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [2:0] o, input logic [15:0] x, input logic [15:0] y,
                        input logic [2:0] d);
    @(negedge clk);
    start = 1'b1; op = o; a = x; b = y; dst = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  // samples from cycle k0 after the start edge until done
  task automatic collect(input int k0);
    int k = k0;
    c_nwr = 0; c_nobusy = 0; c_cyc = -1;
    forever begin
      if (wr_en) begin
        if (c_nwr < 2) begin c_idx[c_nwr] = wr_idx; c_dat[c_nwr] = wr_data; end
        c_nwr++;
      end
      if (!busy) c_nobusy++;
      if (done) begin
        c_cyc = k; c_flt = fault; c_cy = carry; c_zf = zero; c_fwe = flag_we;
        break;
      end
      if (k > 40) begin
        chk("R11", "operation timeout", 32'(k), 32'd17);
        break;
      end
      @(negedge clk);
      k++;
    end
    @(negedge clk);
    c_quiet = !busy && !wr_en && !done && !fault;
  endtask

  task automatic run_mul(input string req, input logic [2:0] o, input logic [15:0] x,
                         input logic [15:0] y, input logic [2:0] d);
    logic signed [15:0] sx = x, sy = y;
    logic [31:0] p;
    logic ov;
    if (o[0]) p = sx * sy; else p = x * y;
    ov = o[0] ? (p[31:16] != {16{p[15]}}) : (p[31:16] != 16'h0);
    launch(o, x, y, d);
    collect(1);
    chk(req, "write count", 32'(c_nwr), 32'd2);
    chk(req, "first idx", 32'(c_idx[0]), 32'd0);
    chk(req, "high half", 32'(c_dat[0]), 32'(p[31:16]));
    chk(req, "second idx", 32'(c_idx[1]), 32'(d));
    chk(req, "low half", 32'(c_dat[1]), 32'(p[15:0]));
    chk("R2", "done cycle", 32'(c_cyc), 32'd2);
    chk("R5", "carry", 32'(c_cy), 32'(ov));
    chk("R5", "zero", 32'(c_zf), 32'(p[15:0] == 16'h0));
    chk("R11", "busy through op", 32'(c_nobusy), 32'd0);
    chk("R11", "idle after done", 32'(c_quiet), 32'd1);
  endtask

  task automatic run_div(input string req, input logic [2:0] o, input logic [15:0] x,
                         input logic [15:0] y, input logic [2:0] d);
    logic signed [15:0] sx = x, sy = y;
    logic [15:0] q, r, e;
    if (o[0]) begin q = sx / sy; r = sx % sy; end
    else      begin q = x / y;   r = x % y;   end
    e = (o == 3'd4 || o == 3'd5) ? r : q;
    launch(o, x, y, d);
    collect(1);
    chk(req, "write count", 32'(c_nwr), 32'd1);
    chk(req, "idx", 32'(c_idx[0]), 32'(d));
    chk(req, "value", 32'(c_dat[0]), 32'(e));
    chk("R11", "done cycle", 32'(c_cyc), 32'd17);
    chk("R10", "carry", 32'(c_cy), 32'd0);
    chk("R10", "zero", 32'(c_zf), 32'(e == 16'h0));
    chk("R10", "flag strobe", 32'(c_fwe), 32'd1);
    chk("R11", "busy through op", 32'(c_nobusy), 32'd0);
    chk("R11", "idle after done", 32'(c_quiet), 32'd1);
  endtask

  task automatic run_fault(input string req, input logic [2:0] o, input logic [15:0] x,
                           input logic [15:0] y);
    launch(o, x, y, 3'd6);
    collect(1);
    chk(req, "no write", 32'(c_nwr), 32'd0);
    chk(req, "fault", 32'(c_flt), 32'd1);
    chk(req, "carry", 32'(c_cy), 32'd1);
    chk(req, "zero", 32'(c_zf), 32'd0);
    chk(req, "done cycle", 32'(c_cyc), 32'd1);
    chk(req, "fault one cycle", 32'(c_quiet), 32'd1);
  endtask

  task automatic t_reset;
    chk("R11", "reset busy", 32'(busy), 32'd0);
    chk("R11", "reset done", 32'(done), 32'd0);
    chk("R2", "reset wr_en", 32'(wr_en), 32'd0);
    chk("R8", "reset fault", 32'(fault), 32'd0);
  endtask

  task automatic t_mul;
    run_mul("R2", 3'd0, 16'hFFFF, 16'hFFFF, 3'd3);
    run_mul("R2", 3'd0, 16'h1234, 16'h0000, 3'd5);
    run_mul("R2", 3'd0, 16'h00FF, 16'h0101, 3'd1);
    run_mul("R3", 3'd1, 16'hFFFF, 16'hFFFF, 3'd2);
    run_mul("R3", 3'd1, 16'hFFFD, 16'd100, 3'd7);
    run_mul("R3", 3'd1, 16'h8000, 16'h8000, 3'd4);
  endtask

  task automatic t_mul_r0;
    logic [15:0] r0 = 16'hDEAD;
    launch(3'd0, 16'h0100, 16'h0300, 3'd0);
    collect(1);
    for (int i = 0; i < 2 && i < c_nwr; i++) if (c_idx[i] == 3'd0) r0 = c_dat[i];
    chk("R4", "writes to R0", 32'(c_nwr), 32'd2);
    chk("R4", "R0 holds low half", 32'(r0), 32'h0000);
    chk("R4", "first write high", 32'(c_dat[0]), 32'h0003);
  endtask

  task automatic t_div;
    run_div("R6", 3'd2, 16'd100, 16'd7, 3'd1);
    run_div("R6", 3'd4, 16'd100, 16'd7, 3'd2);
    run_div("R6", 3'd2, 16'hFFFF, 16'd1, 3'd3);
    run_div("R6", 3'd2, 16'h8000, 16'hFFFF, 3'd4);
    run_div("R6", 3'd4, 16'h8000, 16'hFFFF, 3'd4);
    run_div("R6", 3'd2, 16'd3, 16'd5, 3'd5);
    run_div("R7", 3'd5, 16'd5, -16'sd3, 3'd1);
    run_div("R7", 3'd5, -16'sd5, 16'd3, 3'd2);
    run_div("R7", 3'd5, -16'sd5, -16'sd3, 3'd3);
    run_div("R7", 3'd3, 16'd5, -16'sd3, 3'd4);
    run_div("R7", 3'd3, -16'sd5, -16'sd3, 3'd5);
    run_div("R7", 3'd3, 16'h8000, 16'd2, 3'd6);
    run_div("R7", 3'd5, -16'sd6, 16'd3, 3'd7);
  endtask

  task automatic t_fault;
    run_fault("R8", 3'd2, 16'd9, 16'd0);
    run_fault("R8", 3'd5, 16'h8000, 16'd0);
    run_fault("R9", 3'd3, 16'h8000, 16'hFFFF);
    run_fault("R9", 3'd5, 16'h8000, 16'hFFFF);
  endtask

  task automatic t_busy_ignore;
    launch(3'd0, 16'd3, 16'd4, 3'd5);
    start = 1'b1; op = 3'd2; a = 16'd1; b = 16'd0;
    chk("R12", "hi write kept", 32'(wr_en && wr_idx == 3'd0), 32'd1);
    @(negedge clk);
    start = 1'b0;
    collect(2);
    chk("R12", "low write kept", 32'(c_dat[0]), 32'd12);
    chk("R12", "no fault from ignored start", 32'(c_flt), 32'd0);
    chk("R12", "no extra result", 32'(c_quiet), 32'd1);
  endtask

  task automatic t_bad_op;
    for (int c = 6; c < 8; c++) begin
      @(negedge clk);
      start = 1'b1; op = 3'(c); a = 16'd7; b = 16'd0;
      @(negedge clk);
      start = 1'b0;
      chk("R1", "bad code busy", 32'(busy), 32'd0);
      chk("R12", "bad code quiet", 32'(wr_en || done || fault), 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_mul();
    t_mul_r0();
    t_div();
    t_fault();
    t_busy_ignore();
    t_bad_op();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule